// File: doc/BRIEF.md
# I2C DAC Register Target

This block is the serial front end of a small 8-bit converter-style device. It watches already-synchronized SCL and SDA lines of an I2C bus. It answers only to its own fixed 7-bit address, and it drives the bus through two open-drain pull-low enables, one for SDA and one for SCL. A controller sets up the device with a two-byte write. The first byte carries a 2-bit command, a 2-bit power-down selection and a 4-bit upper nibble. The second byte carries the 8-bit output code. The new code and power-down bits appear on registered outputs only after the second byte has been acknowledged.

A read returns a three-byte sequence: a status/configuration byte, the output code and the stored nibble. The target repeats this sequence for as long as the controller keeps acknowledging. A START or repeated START at any point makes the target wait for a fresh address byte. While an internal ready input is low and the target is addressed, it holds SCL low so that the controller waits.

Top module: `dac_i2c_target`

## Requirements
- R1: After reset, `dac_code_o` and `pd_o` are zero and neither SDA nor SCL is pulled low.
- R2: The target acknowledges (pulls SDA low in the 9th SCL cycle) an address byte whose upper 7 bits equal 7'b1100001, with the LSB as R/W (0 write, 1 read). Any other address is left unacknowledged.
- R3: The general-call address 7'b0000000 is not acknowledged, and the data bytes that follow it change no output.
- R4: A matching address is not acknowledged while `ready_i` is low at the end of the address byte.
- R5: In a write, the first data byte is split as bits [7:6] command, [5:4] power-down and [3:0] upper nibble, and the second data byte is the output code. The target acknowledges both bytes. `dac_code_o` and `pd_o` take the new values two clock cycles after the SCL fall that ends the second acknowledge.
- R6: The outputs do not change unless a complete two-byte write has been acknowledged. A START that arrives after the first data byte discards that byte.
- R7: A read returns, MSB first, byte 0 = {ready, written-flag, 0, command[1:0], power-down[1:0], 0}, then byte 1 = output code, then byte 2 = {4'b0000, nibble}. The sequence wraps back to byte 0 for as long as the controller acknowledges. The written-flag is set by the first complete write.
- R8: When the controller does not acknowledge a read byte, the target releases SDA and drives no further bits until the next START.
- R9: The target begins pulling SDA low only while SCL is low, and its SDA drive never changes while SCL stays high.
- R10: While addressed and with `ready_i` low, the target holds SCL low once SCL is low. It releases SCL one clock after `ready_i` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL bus level |
| sda_i | input | 1 | Synchronized SDA bus level |
| ready_i | input | 1 | Device ready; low requests clock stretching or address refusal |
| sda_pull_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| scl_pull_o | output | 1 | Open-drain enable, 1 pulls SCL low |
| dac_code_o | output | 8 | Registered output code |
| pd_o | output | 2 | Registered power-down bits |

## Verification
The bench addresses a neighbouring address and the general-call address. A decoder that compared too few bits, or that treated zero as a match, would acknowledge those bytes and take their data. A write is cut off after its first byte by a repeated START. A design that committed the byte early, or that kept the staged byte across the START, would change the code at that point. A read runs past the end of the three-byte sequence and then refuses a byte. A design that failed to wrap would return the wrong fourth byte, and one that ignored the refusal would keep driving SDA into the next clocked bit. The stretch test drops ready right after an address acknowledge. A target that did not hold SCL, or that held it after ready came back, would let the controller run ahead or leave the bus stuck.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 4;
  localparam int SEQ_LEN = 3;
  localparam int IDX_W   = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_dac_line_mon.sv
module i2c_dac_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = !scl_q && scl_i;
    scl_fall  = scl_q && !scl_i;
    bus_start = scl_q && scl_i && sda_q && !sda_i;
    bus_stop  = scl_q && scl_i && !sda_q && sda_i;
  end
endmodule

// File: rtl/i2c_dac_engine.sv
module i2c_dac_engine
  import i2c_dac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1100001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              ready_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              sda_pull_o,
  output logic              active_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] wr_first_o,
  output logic [BYTE_W-1:0] wr_second_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

  tgt_state_e        st;
  logic [BYTE_W-1:0] sr, tx, hold1;
  logic [CNT_W-1:0]  bitcnt;
  logic              rw_q, second_q, m_ack;
  logic [IDX_W-1:0]  idx;
  logic              addr_hit;

  assign addr_hit = (sr[BYTE_W-1:1] == DEV_ADDR) && (sr[BYTE_W-1:1] != 7'd0) && ready_i;
  assign rd_idx_o    = idx;
  assign wr_first_o  = hold1;
  assign wr_second_o = sr;
  assign active_o    = (st != ST_IDLE) && (st != ST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      sr         <= '0;
      tx         <= '0;
      hold1      <= '0;
      bitcnt     <= '0;
      rw_q       <= 1'b0;
      second_q   <= 1'b0;
      m_ack      <= 1'b0;
      idx        <= '0;
      sda_pull_o <= 1'b0;
      commit_o   <= 1'b0;
    end else begin
      commit_o <= 1'b0;
      if (bus_start) begin
        st         <= ST_ADDR;
        bitcnt     <= '0;
        second_q   <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (bus_stop) begin
        st         <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sr     <= {sr[BYTE_W-2:0], sda_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              if (addr_hit) begin
                sda_pull_o <= 1'b1;
                rw_q       <= sr[0];
                idx        <= '0;
                st         <= ST_ACK_ADDR;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                tx         <= rd_byte_i;
                sda_pull_o <= !rd_byte_i[BYTE_W-1];
                idx        <= (idx == LAST) ? '0 : idx + 1'b1;
                st         <= ST_RD;
              end else begin
                sda_pull_o <= 1'b0;
                second_q   <= 1'b0;
                st         <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sr     <= {sr[BYTE_W-2:0], sda_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              sda_pull_o <= 1'b1;
              st         <= ST_ACK_WR;
            end
          end
          ST_ACK_WR: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              bitcnt     <= '0;
              st         <= ST_WR;
              if (!second_q) begin
                hold1    <= sr;
                second_q <= 1'b1;
              end else begin
                commit_o <= 1'b1;
                second_q <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == FULL) begin
                sda_pull_o <= 1'b0;
                st         <= ST_RD_ACK;
              end else begin
                sda_pull_o <= !tx[BYTE_W-2];
                tx         <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              m_ack <= !sda_i;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx         <= rd_byte_i;
                sda_pull_o <= !rd_byte_i[BYTE_W-1];
                idx        <= (idx == LAST) ? '0 : idx + 1'b1;
                bitcnt     <= '0;
                st         <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: sda_pull_o <= 1'b0;
        endcase
      end
    end
  end

  AST_PULL_ON_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !$past(scl_i)); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_pull_o); // R8
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= FULL); // R5
endmodule

// File: rtl/i2c_dac_regs.sv
module i2c_dac_regs
  import i2c_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ready_i,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] first_i,
  input  logic [BYTE_W-1:0] second_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic [BYTE_W-1:0] dac_code_o,
  output logic [1:0]        pd_o
);
  logic [1:0] cmd_q;
  logic [3:0] nib_q;
  logic       wrote_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= '0;
      nib_q      <= '0;
      wrote_q    <= 1'b0;
      dac_code_o <= '0;
      pd_o       <= '0;
    end else if (commit_i) begin
      cmd_q      <= first_i[7:6];
      pd_o       <= first_i[5:4];
      nib_q      <= first_i[3:0];
      dac_code_o <= second_i;
      wrote_q    <= 1'b1;
    end
  end

  always_comb begin
    case (rd_idx_i)
      2'd0:    rd_byte_o = {ready_i, wrote_q, 1'b0, cmd_q, pd_o, 1'b0};
      2'd1:    rd_byte_o = dac_code_o;
      default: rd_byte_o = {4'b0000, nib_q};
    endcase
  end

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(commit_i) |-> ($stable(dac_code_o) && $stable(pd_o))); // R6
endmodule

// File: rtl/i2c_dac_stretch.sv
module i2c_dac_stretch (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic active_i,
  input  logic ready_i,
  output logic scl_pull_o
);
  always_ff @(posedge clk) begin
    if (rst) scl_pull_o <= 1'b0;
    else     scl_pull_o <= active_i && !ready_i && (scl_pull_o || !scl_i);
  end

  AST_STRETCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    scl_pull_o |-> $past(!ready_i)); // R10
  AST_STRETCH_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull_o) |-> !$past(scl_i)); // R10
endmodule

// File: rtl/dac_i2c_target.sv
module dac_i2c_target
  import i2c_dac_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1100001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        ready_i,
  output logic        sda_pull_o,
  output logic        scl_pull_o,
  output logic [7:0]  dac_code_o,
  output logic [1:0]  pd_o
);
  logic scl_rise, scl_fall, bus_start, bus_stop;
  logic active, commit;
  logic [BYTE_W-1:0] rd_byte, wr_first, wr_second;
  logic [IDX_W-1:0]  rd_idx;

  i2c_dac_line_mon u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_dac_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ready_i(ready_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .rd_byte_i(rd_byte), .rd_idx_o(rd_idx), .sda_pull_o(sda_pull_o),
    .active_o(active), .commit_o(commit),
    .wr_first_o(wr_first), .wr_second_o(wr_second)
  );

  i2c_dac_regs u_regs (
    .clk(clk), .rst(rst), .ready_i(ready_i), .commit_i(commit),
    .first_i(wr_first), .second_i(wr_second), .rd_idx_i(rd_idx),
    .rd_byte_o(rd_byte), .dac_code_o(dac_code_o), .pd_o(pd_o)
  );

  i2c_dac_stretch u_str (
    .clk(clk), .rst(rst), .scl_i(scl_i), .active_i(active),
    .ready_i(ready_i), .scl_pull_o(scl_pull_o)
  );
endmodule

// File: tb/test_dac_i2c_target.sv
module test_dac_i2c_target;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, ready = 1'b1;
  logic sda_pull, scl_pull;
  logic [7:0] code;
  logic [1:0] pd;
  logic scl_bus, sda_bus;
  int n_cmp = 0, n_bad = 0;
  int cyc = 0;

  logic [7:0] e_code = 8'h00;
  logic [1:0] e_pd = 2'b00, e_cmd = 2'b00;
  logic [3:0] e_nib = 4'h0;
  logic       e_wrote = 1'b0;
  logic       prev_scl = 1'b1, prev_pull = 1'b0;

  assign scl_bus = scl_m & !scl_pull;
  assign sda_bus = sda_m & !sda_pull;

  always #2 clk = !clk;

  dac_i2c_target i_dac_i2c_target (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus), .ready_i(ready),
    .sda_pull_o(sda_pull), .scl_pull_o(scl_pull), .dac_code_o(code), .pd_o(pd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // continuous comparison against the bench model (R5, R6) and SDA stability (R9)
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check("R5/R6 code", {24'h0, code}, {24'h0, e_code});
      check("R5/R6 pd", {30'h0, pd}, {30'h0, e_pd});
      if (scl_bus && prev_scl && (sda_pull != prev_pull))
        check("R9 sda change while scl high", {31'h0, sda_pull}, {31'h0, prev_pull});
    end
    prev_scl  = scl_bus;
    prev_pull = sda_pull;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl_up(); half();
    sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl_up(); half(); sda_m = 1'b1; half();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; half(); scl_up(); half(); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; half(); scl_up(); half(); b = sda_bus; scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = !a;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!give_ack);
  endtask

  task automatic model_commit(input logic [7:0] b1, input logic [7:0] b2);
    @(posedge clk); @(posedge clk); #1;
    e_cmd = b1[7:6]; e_pd = b1[5:4]; e_nib = b1[3:0]; e_code = b2; e_wrote = 1'b1;
  endtask

  task automatic full_write(input logic [7:0] b1, input logic [7:0] b2);
    logic a;
    bus_start();
    send_byte(8'hC2, a); check("R2 write address ack", {31'h0, a}, 32'h1);
    send_byte(b1, a);    check("R5 first byte ack", {31'h0, a}, 32'h1);
    send_byte(b2, a);    check("R5 second byte ack", {31'h0, a}, 32'h1);
    model_commit(b1, b2);
    bus_stop();
  endtask

  initial begin
    logic a, b;
    logic [7:0] rv;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 code reset", {24'h0, code}, 32'h0);
    check("R1 pd reset", {30'h0, pd}, 32'h0);
    check("R1 sda released", {31'h0, sda_pull}, 32'h0);
    check("R1 scl released", {31'h0, scl_pull}, 32'h0);

    // R2: neighbouring address is refused
    bus_start();
    send_byte(8'hC4, a); check("R2 wrong address nack", {31'h0, a}, 32'h0);
    bus_stop();

    // R3: general call refused and its data ignored
    bus_start();
    send_byte(8'h00, a); check("R3 general call nack", {31'h0, a}, 32'h0);
    send_byte(8'h30, a); check("R3 data after general call nack", {31'h0, a}, 32'h0);
    send_byte(8'h55, a);
    bus_stop();
    check("R3 code untouched", {24'h0, code}, 32'h0);

    // R5: write cmd=2 pd=1 nibble=A, code 3C
    full_write(8'b10_01_1010, 8'h3C);
    check("R5 code", {24'h0, code}, 32'h3C);
    check("R5 pd", {30'h0, pd}, 32'h1);

    // R7 / R8: read sequence with wrap, then refusal
    bus_start();
    send_byte(8'hC3, a); check("R2 read address ack", {31'h0, a}, 32'h1);
    recv_byte(rv, 1'b1);
    check("R7 byte0", {24'h0, rv}, {24'h0, 1'b1, e_wrote, 1'b0, e_cmd, e_pd, 1'b0});
    recv_byte(rv, 1'b1); check("R7 byte1", {24'h0, rv}, {24'h0, e_code});
    recv_byte(rv, 1'b1); check("R7 byte2", {24'h0, rv}, {28'h0, e_nib});
    recv_byte(rv, 1'b0);
    check("R7 wrap to byte0", {24'h0, rv}, {24'h0, 1'b1, e_wrote, 1'b0, e_cmd, e_pd, 1'b0});
    get_bit(b); check("R8 sda released after nack", {31'h0, b}, 32'h1);
    check("R8 no pull after nack", {31'h0, sda_pull}, 32'h0);
    bus_stop();

    // R6: partial write cut by repeated START
    bus_start();
    send_byte(8'hC2, a); check("R2 ack before partial write", {31'h0, a}, 32'h1);
    send_byte(8'hF0, a); check("R6 partial first byte ack", {31'h0, a}, 32'h1);
    bus_start();
    check("R6 code unchanged after restart", {24'h0, code}, 32'h3C);
    send_byte(8'hC2, a); check("R6 address after restart", {31'h0, a}, 32'h1);
    send_byte(8'b01_10_0101, a);
    send_byte(8'hA7, a); check("R6 second byte after restart", {31'h0, a}, 32'h1);
    model_commit(8'b01_10_0101, 8'hA7);
    bus_stop();
    check("R6 new code", {24'h0, code}, 32'hA7);
    check("R6 new pd", {30'h0, pd}, 32'h2);

    // R4: busy refuses address
    ready = 1'b0;
    bus_start();
    send_byte(8'hC2, a); check("R4 busy nack", {31'h0, a}, 32'h0);
    bus_stop();
    ready = 1'b1;

    // R10: clock stretching
    bus_start();
    send_byte(8'hC2, a); check("R10 address ack", {31'h0, a}, 32'h1);
    ready = 1'b0;
    fork
      send_byte(8'h00, a);
      begin
        repeat (30) @(negedge clk);
        check("R10 scl held", {31'h0, scl_pull}, 32'h1);
        check("R10 bus scl low", {31'h0, scl_bus}, 32'h0);
        ready = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 scl released", {31'h0, scl_pull}, 32'h0);
      end
    join
    check("R10 byte ack after stretch", {31'h0, a}, 32'h1);
    send_byte(8'h81, a);
    model_commit(8'h00, 8'h81);
    bus_stop();
    check("R10 code after stretch", {24'h0, code}, 32'h81);
    check("R10 pd after stretch", {30'h0, pd}, 32'h0);

    half();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule